// File: doc/BRIEF.md
# Bit-Serial Coefficient Multiplier

This block forms the signed product of a parallel filter coefficient and a two's-complement sample that arrives one bit per clock, least significant bit first. The product leaves the block as a serial stream, also least significant bit first. A transversal filter built from serial arithmetic uses one such multiplier per tap. The coefficient stays parallel and the sample stays serial, so a tap costs one narrow adder and a few registers instead of a full array multiplier. Summing the taps is left to the logic around the block.

The datapath works by shift and add. In each input cycle the current sample bit selects either the coefficient or zero. That value is added to the partial product held in a register. The lowest bit of the sum is sent out, and the rest of the sum is shifted down and kept. The sample's top bit carries negative weight, so in that cycle the coefficient is subtracted instead of added. After the last sample bit, the upper half of the product is shifted out over W more cycles. A parameter selects how the coefficient is gated: either by a plain multiplexer, or by a register that holds the gated value. The register version costs exactly one extra cycle of latency.

Top module: `sermul_coef`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `out_start` and `out_bit` are all low.
- R2: For a word started with `in_start` on sample bit 0, followed by W-1 further bits on consecutive cycles, the block emits 2W bits on `out_bit`, least significant first. Read as a two's-complement number, those bits equal the signed coefficient times the signed W-bit sample.
- R3: The first product bit appears LAT cycles after the cycle in which `in_start` is sampled. LAT is 1 when GATE_REG=0 and 2 when GATE_REG=1.
- R4: `out_start` is high only on the first product bit of a word. `out_valid` is high on exactly 2W consecutive cycles per completed word.
- R5: Sample bit W-1 counts as minus 2^(W-1). Negative samples, including the most negative value, give correct products.
- R6: The coefficient is captured in the `in_start` cycle. Changes on `coef` during the rest of the word have no effect on the product.
- R7: An `in_start` that arrives while a word is still being received or flushed abandons that word and starts a new one. The new word is computed with a cleared partial product.
- R8: A new `in_start` issued exactly 2W cycles after the previous one gives a gapless output: the two products appear back to back and both are correct.
- R9: `in_bit` has no effect while no word is in progress. `out_valid` never rises without `out_start`.
- R10: `out_bit` is low whenever `out_valid` is low.
- R11: The register-gated variant (GATE_REG=1) produces the same bit stream as the multiplexer variant, delayed by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_start | input | 1 | Marks the cycle carrying sample bit 0 |
| in_bit | input | 1 | Serial sample bit, least significant first |
| coef | input | W | Signed parallel coefficient, captured at `in_start` |
| out_start | output | 1 | High on the first (least significant) product bit |
| out_valid | output | 1 | High while product bits are being emitted |
| out_bit | output | 1 | Serial product bit, least significant first |

## Verification
The bench targets the operands at the edge of the range: the most negative coefficient times the most negative sample, zero, minus one, and mixed signs. A design that added instead of subtracted on the sign bit, or that dropped the extra adder bit, would return wrong upper product bits for exactly these cases. It also starts words early, during input and during the flush, and runs words back to back. A partial product that was not cleared would corrupt the next result, and a badly placed start marker would shift every bit. Both gating variants run side by side on the same stimulus, so a stage of latency missing or added in either one shows up as a latency or framing miscompare.

// File: rtl/sermul_pkg.sv
package sermul_pkg;

    // control handed from the gating stage to the accumulator
    typedef struct packed {
        logic start;   // bit 0 of a fresh word
        logic active;  // an input bit of a word is being added
    } gate_ctl_t;

endpackage

// File: rtl/sermul_gate.sv
module sermul_gate
    import sermul_pkg::*;
#(
    parameter int W        = 16,
    parameter bit GATE_REG = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_start,
    input  logic                in_bit,
    input  logic [W-1:0]        coef,
    output gate_ctl_t           g_ctl,
    output logic signed [W:0]   g_addend
);

    localparam int IW = $clog2(W + 1);
    localparam logic [IW-1:0] IDLE = IW'(W);
    localparam logic [IW-1:0] LAST = IW'(W - 1);

    typedef struct packed {
        logic [IW-1:0] idx;   // index of the next expected bit, IDLE when none
        logic [W-1:0]  coef;  // coefficient held for the word
    } gate_st_t;

    gate_st_t          st_d, st_q;
    logic [IW-1:0]     cur;
    logic              active;
    logic [W-1:0]      coef_sel;
    logic signed [W:0] h;
    logic signed [W:0] gated;
    gate_ctl_t         ctl;

    always_comb begin
        st_d     = st_q;
        cur      = in_start ? '0 : st_q.idx;
        active   = in_start || (st_q.idx != IDLE);
        coef_sel = in_start ? coef : st_q.coef;
        h        = $signed({coef_sel[W-1], coef_sel});
        gated    = '0;
        if (active && in_bit) begin
            gated = (cur == LAST) ? -h : h;
        end
        if (in_start) begin
            st_d.coef = coef;
        end
        if (active) begin
            st_d.idx = cur + 1'b1;
        end
        ctl.start  = in_start;
        ctl.active = active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx  <= IDLE;
            st_q.coef <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (GATE_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    g_ctl    <= '0;
                    g_addend <= '0;
                end else begin
                    g_ctl    <= ctl;
                    g_addend <= gated;
                end
            end
        end else begin : g_mux
            assign g_ctl    = ctl;
            assign g_addend = gated;
        end
    endgenerate

endmodule

// File: rtl/sermul_core.sv
module sermul_core
    import sermul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gate_ctl_t         g_ctl,
    input  logic signed [W:0] g_addend,
    output logic              out_start,
    output logic              out_valid,
    output logic              out_bit
);

    localparam int PW = 2 * W;
    localparam int CW = $clog2(PW + 1);
    localparam logic [CW-1:0] DONE = CW'(PW);

    typedef struct packed {
        logic [W:0]    acc;   // partial product, two's complement
        logic [CW-1:0] cnt;   // product bits emitted, DONE when idle
        logic          ob;
        logic          os;
        logic          ov;
    } core_st_t;

    core_st_t            st_d, st_q;
    logic                running;
    logic [W:0]          base;
    logic signed [W+1:0] sum;

    always_comb begin
        st_d    = st_q;
        running = g_ctl.start || (st_q.cnt != DONE);
        base    = g_ctl.start ? '0 : st_q.acc;
        sum     = $signed({base[W], base}) + $signed({g_addend[W], g_addend});
        st_d.ob = 1'b0;
        st_d.os = g_ctl.start;
        st_d.ov = running;
        if (running) begin
            st_d.ob  = sum[0];
            st_d.acc = sum[W+1:1];
            st_d.cnt = (g_ctl.start ? '0 : st_q.cnt) + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
            st_q.cnt <= DONE;
            st_q.ob  <= 1'b0;
            st_q.os  <= 1'b0;
            st_q.ov  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_start = st_q.os;
    assign out_valid = st_q.ov;
    assign out_bit   = st_q.ob;

endmodule

// File: rtl/sermul_coef.sv
module sermul_coef
    import sermul_pkg::*;
#(
    parameter int W        = 16,
    parameter bit GATE_REG = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_start,
    input  logic         in_bit,
    input  logic [W-1:0] coef,
    output logic         out_start,
    output logic         out_valid,
    output logic         out_bit
);

    gate_ctl_t         g_ctl;
    logic signed [W:0] g_addend;

    sermul_gate #(.W(W), .GATE_REG(GATE_REG)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_start (in_start),
        .in_bit   (in_bit),
        .coef     (coef),
        .g_ctl    (g_ctl),
        .g_addend (g_addend)
    );

    sermul_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .g_ctl     (g_ctl),
        .g_addend  (g_addend),
        .out_start (out_start),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

endmodule

// File: rtl/sermul_coef_chk.sv
module sermul_coef_chk #(
    parameter int W        = 16,
    parameter bit GATE_REG = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic in_start,
    input logic out_start,
    input logic out_valid,
    input logic out_bit
);

    localparam int LAT = 1 + int'(GATE_REG);
    localparam int PW  = 2 * W;
    localparam int RW  = $clog2(PW + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (out_valid) begin
            run_q <= out_start ? RW'(1) : run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R3 / R11: start marker appears a fixed number of cycles after the input marker
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_start |-> ##LAT out_start);

    // R4: start marker only on a valid bit
    a_r4_start_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> out_valid);

    // R4: no run longer than 2W bits
    a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_start) |-> (run_q < RW'(PW)));

    // R4: a run that ends has exactly 2W bits
    a_r4_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (run_q == RW'(PW)));

    // R9: valid never rises without a start marker
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_start);

    // R10: quiet output when idle
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_bit);

endmodule

bind sermul_coef sermul_coef_chk #(.W(W), .GATE_REG(GATE_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_start  (in_start),
    .out_start (out_start),
    .out_valid (out_valid),
    .out_bit   (out_bit)
);

// File: tb/test_sermul_coef.sv
module test_sermul_coef;

    localparam int W  = 16;
    localparam int PW = 2 * W;

    typedef struct {
        int               cyc;
        logic [PW-1:0]    prod;
        bit               full;
        string            tag;
    } entry_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_start = 1'b0;
    logic         in_bit = 1'b0;
    logic [W-1:0] coef = '0;
    logic         os [2];
    logic         ov [2];
    logic         ob [2];

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    entry_t        q0 [$];
    entry_t        q1 [$];
    entry_t        cur [2];
    int            n [2];
    logic [PW-1:0] got [2];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sermul_coef #(.W(W), .GATE_REG(1'b0)) i_sermul_coef (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_bit(in_bit), .coef(coef),
        .out_start(os[0]), .out_valid(ov[0]), .out_bit(ob[0])
    );

    sermul_coef #(.W(W), .GATE_REG(1'b1)) i_sermul_coef_reg (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_bit(in_bit), .coef(coef),
        .out_start(os[1]), .out_valid(ov[1]), .out_bit(ob[1])
    );

    function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] c, input logic [W-1:0] s);
        logic signed [PW-1:0] p;
        p = $signed(c) * $signed(s);
        return p;
    endfunction

    task automatic fail(input string msg);
        nfail++;
        $display("FAIL %s", msg);
    endtask

    // output monitor for both variants
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                entry_t e;
                string  vtag;
                vtag = (k == 1) ? "R11 " : "";
                if (!ov[k] && ob[k]) fail($sformatf("%sR10 inst%0d out_bit got 1 exp 0 while idle", vtag, k));
                if (os[k]) begin
                    if (k == 0 && q0.size() == 0 || k == 1 && q1.size() == 0) begin
                        fail($sformatf("%sR9 inst%0d start marker got 1 exp 0", vtag, k));
                    end else begin
                        e = (k == 0) ? q0.pop_front() : q1.pop_front();
                        nchk++;
                        if (cyc - e.cyc != k + 1)
                            fail($sformatf("%sR3 inst%0d latency got %0d exp %0d", vtag, k, cyc - e.cyc, k + 1));
                        cur[k] = e;
                    end
                    n[k] = 0;
                end else if (ov[k] && n[k] == 0) begin
                    fail($sformatf("%sR4 R9 inst%0d valid without start got 1 exp 0", vtag, k));
                end
                if (ov[k]) begin
                    got[k][n[k]] = ob[k];
                    n[k]++;
                    if (n[k] == PW) begin
                        if (cur[k].full) begin
                            nchk++;
                            if (got[k] !== cur[k].prod)
                                fail($sformatf("%s%s inst%0d product got %h exp %h", vtag, cur[k].tag, k, got[k], cur[k].prod));
                        end
                        n[k] = 0;
                    end
                end else if (n[k] != 0) begin
                    fail($sformatf("%sR4 inst%0d run length got %0d exp %0d", vtag, k, n[k], PW));
                    n[k] = 0;
                end
            end
        end
    end

    task automatic run_word(input logic [W-1:0] c, input logic [W-1:0] s,
                            input int nbits, input int gap, input string tag);
        entry_t e;
        @(negedge clk);
        e.cyc  = cyc;
        e.prod = ref_prod(c, s);
        e.full = (nbits == W) && (gap >= W);
        e.tag  = tag;
        q0.push_back(e);
        q1.push_back(e);
        in_start = 1'b1;
        in_bit   = s[0];
        coef     = c;
        for (int i = 1; i < nbits; i++) begin
            @(negedge clk);
            in_start = 1'b0;
            in_bit   = s[i];
            coef     = W'($urandom);    // R6: ignored after capture
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_start = 1'b0;
            in_bit   = 1'($urandom);    // R9: ignored while idle
            coef     = W'($urandom);
        end
    endtask

    initial begin
        logic [W-1:0] c;
        logic [W-1:0] s;
        int           nb;
        int           gp;
        string        tg;
        void'($urandom(32'h1ce5));
        n[0] = 0;
        n[1] = 0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            nchk++;
            if (ov[k] || os[k] || ob[k])
                fail($sformatf("R1 inst%0d reset outputs got %b%b%b exp 000", k, ov[k], os[k], ob[k]));
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            nchk++;
            if (ov[k] || os[k] || ob[k])
                fail($sformatf("R1 inst%0d first cycle outputs got %b%b%b exp 000", k, ov[k], os[k], ob[k]));
        end
        // directed corners
        run_word(16'h8000, 16'h8000, W, W + 2, "R5 min*min");
        run_word(16'h7fff, 16'h8000, W, W + 2, "R5 max*min");
        run_word(16'h8000, 16'h7fff, W, W + 2, "R2 min*max");
        run_word(16'h7fff, 16'h7fff, W, W + 2, "R2 max*max");
        run_word(16'hffff, 16'hffff, W, W + 2, "R5 -1*-1");
        run_word(16'h0000, 16'hffff, W, W + 2, "R2 zero coef");
        run_word(16'h1234, 16'h0000, W, W + 2, "R2 zero sample");
        // back to back, exactly 2W apart
        run_word(16'h0abc, 16'hf123, W, W, "R8 pair a");
        run_word(16'hf00d, 16'h0777, W, W, "R8 pair b");
        run_word(16'h8001, 16'h8001, W, W + 3, "R8 pair c");
        // restart during input and during flush
        run_word(16'h5555, 16'haaaa, W / 2, 0, "R7 aborted");
        run_word(16'h3333, 16'hcccc, W, 3, "R7 aborted flush");
        run_word(16'h0f0f, 16'h9999, W, W + 2, "R7 after restart");
        // random mix
        for (int i = 0; i < 300; i++) begin
            c  = W'($urandom);
            s  = W'($urandom);
            nb = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, W - 1)) : W;
            gp = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, W - 1)) : int'($urandom_range(W, W + 3));
            tg = s[W-1] ? "R5 R6 random" : "R2 R6 random";
            run_word(c, s, nb, gp, tg);
        end
        run_word(16'h4321, 16'h8765, W, PW + 4, "R2 final");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R2 watchdog expired got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule